// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one 16-bit down-counting channel of a three-channel interval timer that sits behind an 8-bit host register port. Address 3 takes control bytes. Addresses 0 to 2 are the data ports of the three channels. A parameter gives this instance its channel number, so three copies share one bus. A control byte programs the channel's operating mode and its BCD flag, freezes the count for reading, or requests a status byte. Counts are written and read as a low byte followed by a high byte through the channel's own data port.

The count drops by one on each cycle in which the count-enable input is high. Two modes are built. In the terminal-count mode the output rises once the count runs out and then stays high. In the rate mode the output drops low for one count period once every N counts, and the count then reloads itself. A loaded value of zero stands for 65536. The rate mode refuses a count of one.

Top module: `pit_channel`

## Requirements
- R1: After reset the output is low, the count is 0, and the status byte is 0x70: null-count set, access 11, mode 0, binary.
- R2: A control byte at address 3 programs this channel only when bits 7:6 equal the channel number, bits 5:4 are 11, and bits 3:1 are 0 or 2. Bit 0 is the BCD flag. Any other such byte changes nothing.
- R3: A count is written to the data port at the channel's own address, low byte first and high byte second. The second byte loads the counter, starts counting and clears the null-count flag. A control byte resets the byte order and sets null-count.
- R4: In mode 0, programming or loading a count drives the output low. The output goes high on the count pulse that takes the count from 1 to 0. It then stays high while the count keeps wrapping down.
- R5: In mode 2 the output is high after programming. It goes low on the pulse that brings the count to 1. On the next pulse it returns high and the loaded value is reloaded, so the period is N pulses.
- R6: A loaded count of 0 acts as 65536. One pulse takes it to 0xFFFF, and in mode 0 the output stays low.
- R7: In mode 2 a written count of 1 is rejected. The old count, the counting and the null-count flag are kept, and the next data write is again a low byte.
- R8: A control byte with bits 5:4 = 00 that selects this channel freezes the count. The next two data reads return the frozen low byte and then the frozen high byte. A further freeze command before both bytes are read is ignored.
- R9: Without a frozen value, data reads return the live count, low byte first and then high byte.
- R10: Control byte 0xE0 OR (2 << channel) captures a status byte. The next data read returns that byte; reads after it return the count again. The status byte is {output, null-count, access[1:0], mode[2:0], BCD}.
- R11: The BCD flag is stored and reported in status bit 0, while counting stays binary.
- R12: The count does not change in cycles where count-enable is low, nor before a count has been loaded after programming.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe; advances the read sequence |
| addr | input | 2 | Register address (3 = control) |
| wrData | input | 8 | Host write byte |
| cntTick | input | 1 | Count-enable pulse |
| rdData | output | 8 | Read byte for the current address (0 for other addresses) |
| outPin | output | 1 | Timer output |

## Verification
The hardest case to reach is a refused count of one in rate mode. It has to land while a valid count is already running, and it can only be seen as what did not change. The stimulus first runs the channel through a whole reload period, so that the count is back at its loaded value. It then writes the two bytes of the value one, reads the frozen count and the status byte, and finally writes a fresh count to show that the byte order came back to the low byte. A second hard case is a freeze command sent while an earlier frozen value is still unread. This is set up by pulsing count-enable between the two commands, so the live count and the frozen count are different.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int CNT_W = 16;
  localparam logic [1:0] CTRL_ADDR = 2'd3;
  localparam logic [1:0] ACC_FREEZE = 2'b00;
  localparam logic [1:0] ACC_WORD = 2'b11;
  localparam logic [2:0] MODE_TERMINAL = 3'd0;
  localparam logic [2:0] MODE_RATE = 3'd2;

  typedef struct packed {
    logic             progMode;
    logic [2:0]       newMode;
    logic             latchCount;
    logic             latchStatus;
    logic             loadCount;
    logic [CNT_W-1:0] loadValue;
  } strobe_t;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int unsigned CHAN_ID = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output strobe_t    stb,
  output logic [2:0] modeReg,
  output logic [1:0] accessReg,
  output logic       bcdReg,
  output logic       rdHigh,
  output logic       cntLatched,
  output logic       statLatched
);
  localparam logic [1:0] CHAN_SEL = CHAN_ID[1:0];

  logic       wrHigh;
  logic [7:0] lowByte;
  logic       ctrlHit, selMine, progOk, latchOk, statusOk, dataWr, dataRd;
  logic [CNT_W-1:0] fullValue;
  logic       commitOk;

  always_comb begin
    ctrlHit   = wrEn && (addr == CTRL_ADDR);
    selMine   = (wrData[7:6] == CHAN_SEL);
    progOk    = ctrlHit && selMine && (wrData[5:4] == ACC_WORD) &&
                ((wrData[3:1] == MODE_TERMINAL) || (wrData[3:1] == MODE_RATE));
    latchOk   = ctrlHit && selMine && (wrData[5:4] == ACC_FREEZE) && !cntLatched;
    statusOk  = ctrlHit && (wrData[7:6] == 2'b11) && !wrData[4] &&
                wrData[1+CHAN_ID] && !statLatched;
    dataWr    = wrEn && (addr == CHAN_SEL);
    dataRd    = rdEn && (addr == CHAN_SEL);
    fullValue = {wrData, lowByte};
    commitOk  = dataWr && wrHigh &&
                !((modeReg == MODE_RATE) && (fullValue == 16'd1));

    stb.progMode    = progOk;
    stb.newMode     = wrData[3:1];
    stb.latchCount  = latchOk;
    stb.latchStatus = statusOk;
    stb.loadCount   = commitOk;
    stb.loadValue   = fullValue;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg     <= MODE_TERMINAL;
      accessReg   <= ACC_WORD;
      bcdReg      <= 1'b0;
      wrHigh      <= 1'b0;
      lowByte     <= 8'd0;
      rdHigh      <= 1'b0;
      cntLatched  <= 1'b0;
      statLatched <= 1'b0;
    end else begin
      if (dataWr) begin
        if (!wrHigh) begin
          lowByte <= wrData;
          wrHigh  <= 1'b1;
        end else begin
          wrHigh  <= 1'b0;
        end
      end
      if (dataRd) begin
        if (statLatched) begin
          statLatched <= 1'b0;
        end else begin
          rdHigh <= !rdHigh;
          if (rdHigh) cntLatched <= 1'b0;
        end
      end
      if (latchOk) begin
        cntLatched <= 1'b1;
        rdHigh     <= 1'b0;
      end
      if (statusOk) statLatched <= 1'b1;
      if (progOk) begin
        modeReg     <= wrData[3:1];
        accessReg   <= wrData[5:4];
        bcdReg      <= wrData[0];
        wrHigh      <= 1'b0;
        rdHigh      <= 1'b0;
        cntLatched  <= 1'b0;
        statLatched <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntTick,
  input  strobe_t          stb,
  input  logic [2:0]       modeReg,
  input  logic [1:0]       accessReg,
  input  logic             bcdReg,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] latchVal,
  output logic [7:0]       statusVal,
  output logic             outPin,
  output logic             nullCount
);
  logic [CNT_W-1:0] reloadVal;
  logic             armed;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal  <= '0;
      reloadVal <= '0;
      latchVal  <= '0;
      statusVal <= 8'd0;
      outPin    <= 1'b0;
      nullCount <= 1'b1;
      armed     <= 1'b0;
    end else begin
      if (stb.latchCount) latchVal <= countVal;
      if (stb.latchStatus)
        statusVal <= {outPin, nullCount, accessReg, modeReg, bcdReg};
      if (stb.progMode) begin
        outPin    <= (stb.newMode == MODE_RATE);
        nullCount <= 1'b1;
        armed     <= 1'b0;
      end else if (stb.loadCount) begin
        countVal  <= stb.loadValue;
        reloadVal <= stb.loadValue;
        nullCount <= 1'b0;
        armed     <= 1'b1;
        outPin    <= (modeReg == MODE_RATE);
      end else if (cntTick && armed) begin
        if (modeReg == MODE_RATE) begin
          if (countVal == 16'd1) begin
            countVal <= reloadVal;
            outPin   <= 1'b1;
          end else begin
            countVal <= countVal - 1'b1;
            if (countVal == 16'd2) outPin <= 1'b0;
          end
        end else begin
          countVal <= countVal - 1'b1;
          if (countVal == 16'd1) outPin <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int unsigned CHAN_ID = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  input  logic       cntTick,
  output logic [7:0] rdData,
  output logic       outPin
);
  localparam logic [1:0] CHAN_SEL = CHAN_ID[1:0];

  strobe_t          stb;
  logic [2:0]       modeReg;
  logic [1:0]       accessReg;
  logic             bcdReg, rdHigh, cntLatched, statLatched, nullCount;
  logic [CNT_W-1:0] countVal, latchVal, readSrc;
  logic [7:0]       statusVal;

  pit_ctrl #(.CHAN_ID(CHAN_ID)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .stb(stb), .modeReg(modeReg), .accessReg(accessReg),
    .bcdReg(bcdReg), .rdHigh(rdHigh), .cntLatched(cntLatched),
    .statLatched(statLatched)
  );

  pit_datapath u_dp (
    .clk(clk), .rstN(rstN), .cntTick(cntTick), .stb(stb), .modeReg(modeReg),
    .accessReg(accessReg), .bcdReg(bcdReg), .countVal(countVal),
    .latchVal(latchVal), .statusVal(statusVal), .outPin(outPin),
    .nullCount(nullCount)
  );

  always_comb begin
    readSrc = cntLatched ? latchVal : countVal;
    if (addr != CHAN_SEL)  rdData = 8'd0;
    else if (statLatched)  rdData = statusVal;
    else                   rdData = rdHigh ? readSrc[15:8] : readSrc[7:0];
  end
endmodule

// File: rtl/pit_channel_chk.sv
module pit_channel_chk
  import pit_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             cntTick,
  input logic             outPin,
  input logic             nullCount,
  input logic [CNT_W-1:0] countVal,
  input logic [2:0]       modeReg,
  input strobe_t          stb
);
  // R1: state right after a reset cycle
  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (!outPin && nullCount && countVal == '0));

  // R3: completing a load clears null-count
  assert_load_clears_null_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCount |=> !nullCount);

  // R4: terminal-count output holds high until reprogrammed or reloaded
  assert_out_held_R4: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_TERMINAL && outPin && !stb.progMode && !stb.loadCount)
    |=> outPin);

  // R5: rate-mode low phase ends on the next count pulse
  assert_low_one_tick_R5: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == MODE_RATE && !outPin && cntTick && !stb.progMode && !stb.loadCount)
    |=> outPin);

  // R7: a count of one never reaches the counter in rate mode
  assert_reject_one_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.loadCount && modeReg == MODE_RATE) |=> (countVal != 16'd1));

  // R12: no count pulse and no load leaves the count unchanged
  assert_idle_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!cntTick && !stb.loadCount) |=> $stable(countVal));
endmodule

bind pit_channel pit_channel_chk u_chk (
  .clk(clk), .rstN(rstN), .cntTick(cntTick), .outPin(outPin),
  .nullCount(nullCount), .countVal(countVal), .modeReg(modeReg), .stb(stb)
);

// File: tb/pit_channel_bench.sv
`timescale 1ns/1ps
module pit_channel_bench;
  localparam int unsigned CH = 1;
  localparam logic [1:0] DATA_ADDR = CH[1:0];

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0, cntTick = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic outPin;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pit_channel #(.CHAN_ID(CH)) u_pit_channel (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .cntTick(cntTick), .rdData(rdData), .outPin(outPin)
  );

  function automatic logic [7:0] ctrlWord(input logic [2:0] m, input logic b);
    return {CH[1:0], 2'b11, m, b};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); cntTick = 1'b1;
      @(negedge clk); cntTick = 1'b0;
    end
  endtask

  task automatic loadCount(input logic [15:0] v);
    busWrite(DATA_ADDR, v[7:0]);
    busWrite(DATA_ADDR, v[15:8]);
  endtask

  task automatic readFrozen(output logic [15:0] v);
    logic [7:0] lo, hi;
    busWrite(2'd3, {CH[1:0], 6'b000000});
    busRead(DATA_ADDR, lo);
    busRead(DATA_ADDR, hi);
    v = {hi, lo};
  endtask

  task automatic readStatus(output logic [7:0] s);
    busWrite(2'd3, 8'hE0 | (8'd2 << CH));
    busRead(DATA_ADDR, s);
  endtask

  task automatic testReset();
    logic [7:0] s; logic [15:0] v;
    @(negedge clk);
    check("R1 out after reset", outPin, 0);
    readStatus(s); check("R1 status after reset", s, 8'h70);
    readFrozen(v); check("R1 count after reset", v, 0);
  endtask

  task automatic testIgnoredControl();
    logic [7:0] s;
    busWrite(2'd3, 8'h34);   // other channel
    busWrite(2'd3, {CH[1:0], 2'b11, 3'd3, 1'b0}); // unsupported mode
    busWrite(2'd3, {CH[1:0], 2'b01, 3'd2, 1'b0}); // unsupported access
    readStatus(s); check("R2 ignored control bytes", s, 8'h70);
    check("R2 out unchanged", outPin, 0);
  endtask

  task automatic testTerminal();
    logic [7:0] s; logic [15:0] v;
    busWrite(2'd3, ctrlWord(3'd0, 1'b0));
    readStatus(s); check("R3 null set after control", s, 8'h70);
    loadCount(16'd5);
    readStatus(s); check("R3 null cleared after load", s, 8'h30);
    tick(4);
    check("R4 out low before terminal", outPin, 0);
    readFrozen(v); check("R4 count at 1", v, 1);
    tick(1);
    @(negedge clk); check("R4 out high at terminal", outPin, 1);
    tick(2);
    @(negedge clk); check("R4 out stays high", outPin, 1);
    readFrozen(v); check("R4 count wraps", v, 16'hFFFE);
  endtask

  task automatic testRate();
    logic [7:0] s; logic [15:0] v;
    int expOut[6] = '{1, 0, 1, 1, 0, 1};
    busWrite(2'd3, ctrlWord(3'd2, 1'b0));
    readStatus(s); check("R5 status after rate program", s, 8'hF4);
    loadCount(16'd3);
    for (int i = 0; i < 6; i++) begin
      tick(1);
      @(negedge clk); check($sformatf("R5 out after pulse %0d", i + 1), outPin, expOut[i]);
    end
    loadCount(16'd1);
    readFrozen(v); check("R7 count kept after reject", v, 3);
    readStatus(s); check("R7 status kept after reject", s, 8'hB4);
    tick(1);
    readFrozen(v); check("R7 counting continues", v, 2);
    loadCount(16'd4);
    readFrozen(v); check("R7 byte order restored", v, 4);
  endtask

  task automatic testZeroCount();
    logic [15:0] v;
    busWrite(2'd3, ctrlWord(3'd0, 1'b0));
    loadCount(16'd0);
    readFrozen(v); check("R6 zero loaded", v, 0);
    tick(1);
    readFrozen(v); check("R6 zero wraps to FFFF", v, 16'hFFFF);
    check("R6 out stays low", outPin, 0);
  endtask

  task automatic testFreezeAndLive();
    logic [7:0] lo, hi, s;
    busWrite(2'd3, ctrlWord(3'd2, 1'b0));
    loadCount(16'h1234);
    tick(2);
    busWrite(2'd3, {CH[1:0], 6'b000000});
    tick(3);
    busWrite(2'd3, {CH[1:0], 6'b000000}); // ignored: value still frozen
    busRead(DATA_ADDR, lo); busRead(DATA_ADDR, hi);
    check("R8 frozen value", {hi, lo}, 16'h1232);
    busRead(DATA_ADDR, lo); busRead(DATA_ADDR, hi);
    check("R9 live value", {hi, lo}, 16'h122F);
    readStatus(s); check("R10 status byte", s, 8'hB4);
    busRead(DATA_ADDR, lo); busRead(DATA_ADDR, hi);
    check("R10 count read after status", {hi, lo}, 16'h122F);
  endtask

  task automatic testBcdAndIdle();
    logic [7:0] s; logic [15:0] v;
    busWrite(2'd3, ctrlWord(3'd0, 1'b1));
    loadCount(16'h0010);
    tick(1);
    readFrozen(v); check("R11 binary decrement", v, 16'h000F);
    readStatus(s); check("R11 BCD flag in status", s, 8'h31);
    repeat (5) @(negedge clk);
    readFrozen(v); check("R12 no pulse keeps count", v, 16'h000F);
    busWrite(2'd3, ctrlWord(3'd0, 1'b0));
    tick(3);
    readFrozen(v); check("R12 unloaded channel holds", v, 16'h000F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIgnoredControl();
    testTerminal();
    testRate();
    testZeroCount();
    testFreezeAndLive();
    testBcdAndIdle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule